// File: doc/BRIEF.md
# Stepwise Bidirectional Logical Shifter

This block shifts an unsigned data word by a signed distance, one bit position per clock. A load captures the data word, a direction bit and a distance magnitude. The block then moves the word one place per cycle under a down-counter. Vacated positions always fill with zero and bits pushed past either end are lost. Once the counter is exhausted, a completion flag rises one cycle later, and the result then holds until the next load.

It suits datapaths where shift latency is less important than area: no barrel network is built, only one two-way multiplexer per bit and a small counter. Synchronous reset behaves exactly like a load of whatever operands are present on the inputs. A load that arrives while an operation is still running discards that operation and starts the new one.

Top module: `seq_step_shifter`

## Requirements
- R1: While `rst` is high, each clock edge copies `din` into `result`, the magnitude into the counter and the direction into the direction register, and it clears `done`. After release, the block runs that operation like any other.
- R2: A clock edge with `load` high copies `din` into `result`, copies `amt_mag` into the counter and `amt_neg` into the direction register, and clears `done`. Operand inputs are ignored at all other edges.
- R3: With `amt_neg` = 0 (upward), each step moves `result` one place toward the MSB, puts 0 into bit 0 and drops the old MSB.
- R4: With `amt_neg` = 1 (downward), each step moves `result` one place toward the LSB, puts 0 into the MSB and drops the old bit 0.
- R5: After a load of magnitude M, exactly M steps occur on the M edges that follow. `done` rises on edge M+1 after the load edge. The counter decrements on every step edge.
- R6: Once `done` is high and no load occurs, `result` and `done` stay unchanged, and the counter holds at zero.
- R7: A magnitude of 0 leaves `result` equal to the loaded word and raises `done` on the first edge after the load.
- R8: A magnitude of at least DATA_W gives a result of all zeros in either direction. Magnitudes up to 2^CNT_W − 1 are accepted.
- R9: A load during a running operation abandons it and restarts with the new operands, with the R5 timing counted from the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, acts as a load |
| load | input | 1 | Captures operands and starts an operation |
| din | input | DATA_W | Unsigned word to be shifted |
| amt_neg | input | 1 | Sign of the distance: 0 upward, 1 downward |
| amt_mag | input | CNT_W | Magnitude of the shift distance |
| result | output | DATA_W | Shift register contents |
| done | output | 1 | High once the operation has finished |

## Verification
After the load edge, `result` carries the loaded word. After edge j (for j up to M), it carries the word shifted by j places. `done` first reads high after edge M+1, and the outputs are then frozen. The bench drives every input on the falling edge. It samples on each falling edge after the load and compares against the word shifted by the number of rising edges seen so far, capped at M. This gives both the per-step contents and the exact cycle in which `done` rises. During the hold cycles and the running cycles, the bench changes the operand inputs at random, which shows that only a load edge captures them.

// File: rtl/stepshift_pkg.sv
package stepshift_pkg;

    localparam int unsigned DEF_DATA_W = 14;
    localparam int unsigned DEF_CNT_W  = 5;

    typedef enum logic {
        SHIFT_UP   = 1'b0,
        SHIFT_DOWN = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic step;
        logic finish;
    } seq_ctl_t;

    function automatic seq_ctl_t decode_ctl(input logic cnt_zero, input logic done_now);
        seq_ctl_t c;
        c.step   = !done_now && !cnt_zero;
        c.finish = !done_now && cnt_zero;
        return c;
    endfunction

    function automatic shift_dir_e to_dir(input logic neg);
        return neg ? SHIFT_DOWN : SHIFT_UP;
    endfunction

endpackage

// File: rtl/stepshift_counter.sv
module stepshift_counter
    import stepshift_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] mag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             step_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    seq_ctl_t         ctl;

    always_comb begin
        ctl = decode_ctl(cnt_q == '0, done_q);
    end

    always_ff @(posedge clk) begin
        if (restart_i) begin
            cnt_q  <= mag_i;
            done_q <= 1'b0;
        end else if (ctl.step) begin
            cnt_q  <= cnt_q - 1'b1;
        end else if (ctl.finish) begin
            done_q <= 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign step_o = ctl.step;
    assign done_o = done_q;
endmodule

// File: rtl/stepshift_datapath.sv
module stepshift_datapath
    import stepshift_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              neg_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] result_o,
    output shift_dir_e        dir_o
);
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_nx;
    shift_dir_e        dir_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_lsb
            assign from_below = 1'b0;
        end else begin : g_mid_lo
            assign from_below = word_q[i-1];
        end
        if (i == DATA_W - 1) begin : g_msb
            assign from_above = 1'b0;
        end else begin : g_mid_hi
            assign from_above = word_q[i+1];
        end
        assign word_nx[i] = (dir_q == SHIFT_DOWN) ? from_above : from_below;
    end

    always_ff @(posedge clk) begin
        if (restart_i) begin
            word_q <= din_i;
            dir_q  <= to_dir(neg_i);
        end else if (step_i) begin
            word_q <= word_nx;
        end
    end

    assign result_o = word_q;
    assign dir_o    = dir_q;
endmodule

// File: rtl/seq_step_shifter.sv
module seq_step_shifter
    import stepshift_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              amt_neg,
    input  logic [CNT_W-1:0]  amt_mag,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic             restart;
    logic             step;
    logic [CNT_W-1:0] cnt_q;
    shift_dir_e       dir_q;

    assign restart = rst | load;

    stepshift_counter #(.CNT_W(CNT_W)) ctr_i (
        .clk       (clk),
        .restart_i (restart),
        .mag_i     (amt_mag),
        .cnt_o     (cnt_q),
        .step_o    (step),
        .done_o    (done)
    );

    stepshift_datapath #(.DATA_W(DATA_W)) dp_i (
        .clk       (clk),
        .restart_i (restart),
        .din_i     (din),
        .neg_i     (amt_neg),
        .step_i    (step),
        .result_o  (result),
        .dir_o     (dir_q)
    );
endmodule

// File: rtl/seq_step_shifter_chk.sv
module seq_step_shifter_chk #(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [DATA_W-1:0] din,
    input logic              amt_neg,
    input logic [CNT_W-1:0]  amt_mag,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic [CNT_W-1:0]  cnt,
    input logic              dir
);
    // R2: load captures operands and clears done
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (result == $past(din)) && !done && (cnt == $past(amt_mag)) && (dir == $past(amt_neg)));

    // R3: upward step
    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (!load && !done && cnt != '0 && dir == 1'b0) |=> result == ($past(result) << 1));

    // R4: downward step
    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (!load && !done && cnt != '0 && dir == 1'b1) |=> result == ($past(result) >> 1));

    // R5: counter decrements on each step
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && !done && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)) && !done);

    // R5: done rises one edge after the count reaches zero
    a_r5_done_after_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && !done && cnt == '0) |=> done && $stable(result));

    // R6: frozen once finished
    a_r6_hold_finished: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done && $stable(result) && cnt == '0);
endmodule

bind seq_step_shifter seq_step_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .din     (din),
    .amt_neg (amt_neg),
    .amt_mag (amt_mag),
    .result  (result),
    .done    (done),
    .cnt     (cnt_q),
    .dir     (dir_q)
);

// File: tb/seq_step_shifter_tb_top.sv
module seq_step_shifter_tb_top;
    localparam int DATA_W = 14;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              load;
    logic [DATA_W-1:0] din;
    logic              amt_neg;
    logic [CNT_W-1:0]  amt_mag;
    logic [DATA_W-1:0] result;
    logic              done;

    int vec_cnt = 0;
    int bad_cnt = 0;

    always #4 clk = ~clk;

    seq_step_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .load(load), .din(din),
        .amt_neg(amt_neg), .amt_mag(amt_mag), .result(result), .done(done)
    );

    function automatic logic [DATA_W-1:0] ref_shift(input logic [DATA_W-1:0] x,
                                                    input logic neg, input int k);
        logic [DATA_W-1:0] v = x;
        for (int i = 0; i < k; i++) v = neg ? {1'b0, v[DATA_W-1:1]} : {v[DATA_W-2:0], 1'b0};
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scramble();
        din     = DATA_W'($urandom);
        amt_neg = 1'($urandom);
        amt_mag = CNT_W'($urandom);
    endtask

    task automatic start_op(input logic [DATA_W-1:0] x, input logic neg, input logic [CNT_W-1:0] m);
        @(negedge clk);
        load = 1'b1; din = x; amt_neg = neg; amt_mag = m;
        @(negedge clk);
        load = 1'b0;
        scramble();
        check("R2 load word", result, x);
        check("R2 done cleared", done, 0);
    endtask

    task automatic follow_op(input logic [DATA_W-1:0] x, input logic neg, input int m);
        for (int j = 1; j <= m + 1; j++) begin
            @(negedge clk);
            scramble();
            check(neg ? "R4 down step" : "R3 up step", result, ref_shift(x, neg, (j > m) ? m : j));
            check("R5 done timing", done, (j == m + 1) ? 1 : 0);
        end
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            scramble();
            check("R6 hold result", result, ref_shift(x, neg, m));
            check("R6 hold done", done, 1);
        end
    endtask

    task automatic run_op(input logic [DATA_W-1:0] x, input logic neg, input logic [CNT_W-1:0] m);
        start_op(x, neg, m);
        follow_op(x, neg, int'(m));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad_cnt++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] ex;
        void'($urandom(32'd20240611));
        ex = 14'b01110111010010;
        rst = 1'b1; load = 1'b0; din = ex; amt_neg = 1'b0; amt_mag = 5'd2;
        repeat (2) @(negedge clk);
        check("R1 reset word", result, ex);
        check("R1 reset done low", done, 0);
        rst = 1'b0;
        follow_op(ex, 1'b0, 2);

        run_op(ex, 1'b0, 5'd5);
        check("R3 example up", result, 14'b11101001000000);
        run_op(ex, 1'b1, 5'd5);
        check("R4 example down", result, 14'b00000011101110);

        run_op(14'h2A5B, 1'b0, 5'd0);
        check("R7 zero magnitude", result, 14'h2A5B);
        run_op(14'h1234, 1'b1, 5'd0);

        run_op(14'h3FFF, 1'b0, 5'd14);
        check("R8 up full width", result, 0);
        run_op(14'h3FFF, 1'b1, 5'd31);
        check("R8 down max magnitude", result, 0);
        run_op(14'h3FFF, 1'b1, 5'd13);
        check("R8 one bit left", result, 1);

        start_op(14'h0F0F, 1'b0, 5'd10);
        repeat (3) @(negedge clk);
        check("R9 midway", result, ref_shift(14'h0F0F, 1'b0, 3));
        run_op(14'h3C01, 1'b1, 5'd4);
        check("R9 restarted result", result, 14'h03C0);

        for (int n = 0; n < 40; n++) begin
            run_op(DATA_W'($urandom), 1'($urandom), CNT_W'($urandom_range(0, 20)));
        end
        finish_run();
    end
endmodule